// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block caches virtual-to-physical page translations for data accesses. It has a fixed number of slots and each virtual page can sit in only one of them. A lookup presents a 32-bit virtual address with an enable strobe. On the next clock edge the block registers its result: whether the page is present, the physical page number, four access-permission flags (read and write, for user and for supervisor mode) and a cache-inhibit flag. The enclosing memory-management logic decides faults and routes addresses from that result.

Software fills and inspects the slots through a register port, which has a select, a write strobe, an address and 32-bit write and read data. Each slot is exposed as two words. The tag word holds the virtual page and the valid flag. The mapping word holds the physical page, the permissions and the cache-inhibit flag. The two words sit in separate address windows. With the default parameters there are 64 slots and pages are 8 KB.

Top module: `dtlb_dm`

## Requirements
- R1: Slot index is virtual address bits 18:13 and the stored tag is bits 31:19. A lookup hits when the indexed slot is valid and its stored tag equals address bits 31:19.
- R2: When `lookup_en` is high at a clock edge, `hit`, `ppn`, the four permission flags and `ci` show that lookup's result after the edge. When `lookup_en` is low at an edge, `hit` goes low and the other result outputs keep their values.
- R3: A write with `reg_cs` and `reg_we` high to address 0x0A00+i (i in 0..63) sets slot i's tag from write data bits 31:19 and its valid flag from write data bit 0.
- R4: A write to address 0x0B00+i sets slot i's physical page from write data bits 31:13. It also sets supervisor-write from bit 9, supervisor-read from bit 8, user-write from bit 7, user-read from bit 6 and cache-inhibit from bit 1.
- R5: With `reg_cs` high and address 0x0A00+i, `reg_rdata` shows slot i's tag word in the same cycle. Bits 31:19 hold the tag, bits 18:13 hold i, bits 12:1 are zero and bit 0 is the valid flag.
- R6: With `reg_cs` high and address 0x0B00+i, `reg_rdata` shows slot i's mapping word in the same cycle. Bits 31:13 hold the physical page, bits 9..6 hold the permissions as in R4, bit 1 holds cache-inhibit and all other bits are zero.
- R7: `reg_rdata` is zero when `reg_cs` is low or the address is outside both windows. Writes outside both windows change no slot.
- R8: Reset clears every valid flag and the registered result outputs, so every lookup misses until software writes a tag word.
- R9: When a register write and a lookup of the same slot happen at one edge, the lookup sees the slot's contents from before the write.
- R10: A tag-word write leaves the slot's mapping word unchanged, and a mapping-word write leaves the tag word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_en | input | 1 | Lookup request strobe |
| vaddr | input | 32 | Virtual address to translate |
| hit | output | 1 | Registered translation present |
| ppn | output | 19 | Registered physical page number |
| ure | output | 1 | User read allowed |
| uwe | output | 1 | User write allowed |
| sre | output | 1 | Supervisor read allowed |
| swe | output | 1 | Supervisor write allowed |
| ci | output | 1 | Cache inhibit |
| reg_cs | input | 1 | Register port select |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 32 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench builds the block with its default parameters: 64 slots and a 13-bit page offset. This keeps the address windows 0x0A00–0x0A3F and 0x0B00–0x0B3F and the 13-bit tag at their stated positions. All 64 slots are filled, so every index and both windows are reached. Random traffic mixes hitting and missing lookups, idle cycles, writes to both windows and accesses just outside them. Directed steps cover a write and a lookup to the same slot at one edge, and a reset in the middle of the run that must invalidate every slot.

// File: rtl/dtlb_dm.sv
module dtlb_dm #(
  parameter int          ENTRIES    = 64,
  parameter int          PAGE_SHIFT = 13,
  parameter logic [15:0] TAG_BASE   = 16'h0A00,
  parameter logic [15:0] MAP_BASE   = 16'h0B00
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lookup_en,
  input  logic [31:0]            vaddr,
  output logic                   hit,
  output logic [31-PAGE_SHIFT:0] ppn,
  output logic                   ure,
  output logic                   uwe,
  output logic                   sre,
  output logic                   swe,
  output logic                   ci,
  input  logic                   reg_cs,
  input  logic                   reg_we,
  input  logic [31:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = 32 - PAGE_SHIFT - IDX_W;
  localparam int PPN_W = 32 - PAGE_SHIFT;
  localparam logic [31:0] TAG_B = {16'h0, TAG_BASE};
  localparam logic [31:0] MAP_B = {16'h0, MAP_BASE};

  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [PPN_W-1:0]   ppn_mem  [ENTRIES];
  logic [4:0]         attr_mem [ENTRIES];

  wire [IDX_W-1:0] va_idx = vaddr[PAGE_SHIFT +: IDX_W];
  wire [TAG_W-1:0] va_tag = vaddr[31 -: TAG_W];
  wire [IDX_W-1:0] r_idx  = reg_addr[IDX_W-1:0];
  wire sel_tag = reg_cs && (reg_addr[31:IDX_W] == TAG_B[31:IDX_W]);
  wire sel_map = reg_cs && (reg_addr[31:IDX_W] == MAP_B[31:IDX_W]);

  always_ff @(posedge clk) begin
    if (rst)
      valid <= '0;
    else if (sel_tag && reg_we)
      valid[r_idx] <= reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (sel_tag && reg_we)
      tag_mem[r_idx] <= reg_wdata[31 -: TAG_W];
    if (sel_map && reg_we) begin
      ppn_mem[r_idx]  <= reg_wdata[31 -: PPN_W];
      attr_mem[r_idx] <= {reg_wdata[9:6], reg_wdata[1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      ppn <= '0;
      {swe, sre, uwe, ure, ci} <= '0;
    end else if (lookup_en) begin
      hit <= valid[va_idx] && (tag_mem[va_idx] == va_tag);
      ppn <= ppn_mem[va_idx];
      {swe, sre, uwe, ure, ci} <= attr_mem[va_idx];
    end else begin
      hit <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_tag)
      reg_rdata = {tag_mem[r_idx], r_idx, {(PAGE_SHIFT-1){1'b0}}, valid[r_idx]};
    else if (sel_map)
      reg_rdata = {ppn_mem[r_idx], {(PAGE_SHIFT-10){1'b0}}, attr_mem[r_idx][4:1],
                   4'b0, attr_mem[r_idx][0], 1'b0};
  end

  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(lookup_en));

  // R2
  idle_holds_ppn_chk: assert property (@(posedge clk) disable iff (rst)
    (!lookup_en && !$past(rst)) |=> ($stable(ppn) && !hit));

  // R5
  tag_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel_tag |-> (reg_rdata[PAGE_SHIFT-1:1] == '0 && reg_rdata[PAGE_SHIFT +: IDX_W] == reg_addr[IDX_W-1:0]));

  // R6
  map_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel_map |-> (reg_rdata[5:2] == 4'b0 && reg_rdata[0] == 1'b0));

  // R7
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_cs |-> (reg_rdata == 32'h0));

  // R8
  reset_miss_chk: assert property (@(posedge clk)
    $past(rst) |-> !hit);
endmodule

// File: tb/test_dtlb_dm.sv
module test_dtlb_dm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, lookup_en = 0, reg_cs = 0, reg_we = 0;
  logic [31:0] vaddr = 0, reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [18:0] ppn;
  logic        hit, ure, uwe, sre, swe, ci;

  int checks = 0, errors = 0;

  bit        mv[64];
  bit [12:0] mtag[64];
  bit [18:0] tppn[64];
  bit [4:0]  tat[64];
  bit        km[64], kt[64];
  bit        e_hit, e_known;
  bit [18:0] e_ppn;
  bit [4:0]  e_at;

  dtlb_dm i_dtlb_dm (
    .clk(clk), .rst(rst), .lookup_en(lookup_en), .vaddr(vaddr),
    .hit(hit), .ppn(ppn), .ure(ure), .uwe(uwe), .sre(sre), .swe(swe), .ci(ci),
    .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_result(input string req);
    chk({req, " hit"}, {31'b0, hit}, {31'b0, e_hit});
    if (e_known) begin
      chk({req, " ppn"}, {13'b0, ppn}, {13'b0, e_ppn});
      chk({req, " attr"}, {27'b0, swe, sre, uwe, ure, ci}, {27'b0, e_at});
    end
  endtask

  task automatic step(input logic en, input logic [31:0] va, input logic cs,
                      input logic we, input logic [31:0] ra, input logic [31:0] wd,
                      input string req);
    int i;
    bit tsel, msel;
    logic [31:0] exp_rd, mask;
    lookup_en = en; vaddr = va; reg_cs = cs; reg_we = we; reg_addr = ra; reg_wdata = wd;
    #1;
    i = ra[5:0];
    tsel = cs && (ra[31:6] == 26'h28);
    msel = cs && (ra[31:6] == 26'h2C);
    exp_rd = 0; mask = 32'hFFFF_FFFF;
    if (tsel) begin
      exp_rd = {mtag[i], ra[5:0], 12'b0, mv[i]};
      if (!km[i]) mask = 32'h0007_FFFF;
      chk("R5 tag read", reg_rdata & mask, exp_rd & mask);
    end else if (msel) begin
      exp_rd = {tppn[i], 3'b0, tat[i][4:1], 4'b0, tat[i][0], 1'b0};
      if (kt[i]) chk("R6 map read", reg_rdata, exp_rd);
      else chk("R6 map read zeros", reg_rdata & 32'h0000_1C3D, 32'h0);
    end else begin
      chk("R7 idle read", reg_rdata, 32'h0);
    end
    if (en) begin
      i = va[18:13];
      e_hit = mv[i] && (mtag[i] == va[31:19]);
      e_ppn = tppn[i]; e_at = tat[i]; e_known = kt[i];
    end else begin
      e_hit = 0;
    end
    if (we) begin
      i = ra[5:0];
      if (tsel) begin mv[i] = wd[0]; mtag[i] = wd[31:19]; km[i] = 1; end
      if (msel) begin tppn[i] = wd[31:13]; tat[i] = {wd[9:6], wd[1]}; kt[i] = 1; end
    end
    @(posedge clk); @(negedge clk);
    check_result(req);
  endtask

  task automatic do_reset();
    rst = 1; lookup_en = 0; reg_cs = 0; reg_we = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int k = 0; k < 64; k++) mv[k] = 0;
    e_hit = 0; e_ppn = 0; e_at = 0; e_known = 1;
    chk("R8 reset hit", {31'b0, hit}, 32'h0);
    chk("R8 reset ppn", {13'b0, ppn}, 32'h0);
    chk("R8 reset attr", {27'b0, swe, sre, uwe, ure, ci}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] va, ra;
    void'($urandom(7));
    @(negedge clk);
    do_reset();
    for (int k = 0; k < 64; k++)
      step(1, {13'($urandom), 6'(k), 13'h0}, 1, 0, 32'h0A00 + k, 0, "R8 miss after reset");
    for (int k = 0; k < 64; k++)
      step(0, 0, 1, 1, 32'h0B00 + k, $urandom, "R4 map fill");
    for (int k = 0; k < 64; k++)
      step(0, 0, 1, 1, 32'h0A00 + k, {13'(k * 37 + 5), 18'h0, 1'(k % 2 == 0)}, "R3 tag fill");
    for (int k = 0; k < 64; k++)
      step(1, {13'(k * 37 + 5), 6'(k), 13'($urandom)}, 1, 0, 32'h0B00 + k, 0, "R1 lookup sweep");
    for (int n = 0; n < 1500; n++) begin
      int s = $urandom % 64;
      va = ($urandom % 2) ? {mtag[s], 6'(s), 13'($urandom)} : $urandom;
      case ($urandom % 6)
        0: ra = 32'h0A00 + ($urandom % 64);
        1: ra = 32'h0B00 + ($urandom % 64);
        2: ra = 32'h0A40 + ($urandom % 64);
        3: ra = 32'h0C00 + ($urandom % 64);
        4: ra = 32'h0AFF;
        default: ra = 32'h1_0A00 + ($urandom % 64);
      endcase
      step(1'($urandom), va, 1'($urandom), 1'($urandom % 4 == 0), ra,
           $urandom, "R2 R10 random");
    end
    step(0, 0, 1, 1, 32'h0A05, {13'h1ABC, 18'h0, 1'b1}, "R3 set slot 5");
    step(1, {13'h1ABC, 6'd5, 13'h0}, 1, 1, 32'h0A05, 32'h0, "R9 same-edge invalidate");
    step(1, {13'h1ABC, 6'd5, 13'h0}, 0, 0, 0, 0, "R3 invalidated miss");
    step(1, {13'h1ABC, 6'd5, 13'h0}, 1, 1, 32'h0A3F + 1, 32'h3579_0001, "R7 outside write");
    step(0, 0, 1, 0, 32'h0A00, 0, "R7 slot 0 untouched");
    step(0, 0, 0, 1, 32'h0A00, 32'hFFFF_FFFF, "R7 write without select");
    step(0, 0, 1, 0, 32'h0A00, 0, "R7 slot 0 still untouched");
    step(1, {mtag[2], 6'd2, 13'h0}, 0, 0, 0, 0, "R1 pre-reset hit");
    do_reset();
    for (int k = 0; k < 64; k++)
      step(1, {mtag[k], 6'(k), 13'h1}, 1, 0, 32'h0A00 + k, 0, "R8 miss after second reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule